// File: doc/BRIEF.md
# Sleep State Controller

This block is the power-management state machine that moves a system between the working state (S0) and four sleep depths: S1, S3, S4 and S5. Software picks a depth by writing a three-bit sleep-type code into a holding register. A separate sleep-enable strobe then starts the entry. A graceful entry first raises the processor stop-clock request. It then waits for the processor's stop-grant acknowledge, and only after that drives the sleep rail controls that match the chosen depth.

A power button held through more than `OVR_TICKS` ticks of a slow always-on tick forces the controller straight into S5. This override path does not wait for any acknowledge, and it can start from S0, from a pending entry, or from a shallower sleep. A wake event brings the controller back to S0 and sets a sticky wake status flag, which software clears by writing a one. While the low-battery input is high, no wake is attempted. A wake event seen in that period is held as pending and takes effect once low-battery drops. Throttling is forced off from the cycle after sleep-enable is accepted until the controller is back in S0.

Top module: `pm_sleep_ctrl`

## Requirements
- R1: Sleep-type codes are 3'b001 for S1, 3'b101 for S3, 3'b110 for S4 and 3'b111 for S5. The code is latched on `type_wr`. A `sleep_go` in S0 with a valid latched code drives `stpclk_n` low at the next edge. With any other code, `sleep_go` changes no output.
- R2: After an accepted `sleep_go`, all rail outputs stay high until `stop_grant` is sampled high. The sleep outputs take effect at the edge that samples `stop_grant`.
- R3: In S1, `stpclk_n` is low and all three rail outputs (`rail_a_n`, `rail_b_n`, `rail_c_n`) are high.
- R4: In S3 only `rail_a_n` is low. In S4 `rail_a_n` and `rail_b_n` are low. In S5 all three rails are low. In every sleep state `stpclk_n` is low.
- R5: With `btn_pressed` held high, the controller enters S5 (all rails low, `stpclk_n` low) at the edge that samples the (OVR_TICKS+1)-th `slow_tick`. No `stop_grant` is needed, and this applies from S0, from a pending entry or from a shallower sleep.
- R6: If `btn_pressed` is low for even one clock, the tick count restarts from zero.
- R7: In a sleep state, with `bat_low` low, a `wake_evt` returns the controller to S0 at the next edge (`stpclk_n` high, all rails high) and sets `wake_sts`.
- R8: While `bat_low` is high, a sleeping controller stays asleep. A `wake_evt` seen then is held, and the wake happens at the first edge where `bat_low` is sampled low.
- R9: `throttle_off` is high in every cycle in which the controller is not in S0, starting from the cycle after an accepted `sleep_go`.
- R10: `wake_sts` stays set until a cycle with `wake_sts_w1c` high. If a wake and a clear happen at the same edge, the flag ends up set.
- R11: A `sleep_go` that arrives while the controller is not in S0 is ignored. A `wake_evt` that arrives in S0 or during a pending entry is ignored and is not held for later.
- R12: When an override and a wake happen at the same edge, the override wins. The controller ends in S5, any pending wake is dropped, and `wake_sts` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse from the always-on time base |
| type_wr | input | 1 | Latches `type_in` into the sleep-type register |
| type_in | input | 3 | Sleep-type code |
| sleep_go | input | 1 | Sleep-enable strobe |
| stop_grant | input | 1 | Processor stop-grant acknowledge |
| btn_pressed | input | 1 | Power button currently held |
| wake_evt | input | 1 | Combined wake event |
| bat_low | input | 1 | Low-battery indication, blocks wake |
| wake_sts_w1c | input | 1 | Write-one-to-clear for `wake_sts` |
| stpclk_n | output | 1 | Processor stop-clock request, active low |
| rail_a_n | output | 1 | Non-critical power rail off, active low (S3 and deeper) |
| rail_b_n | output | 1 | Memory power off, active low (S4 and deeper) |
| rail_c_n | output | 1 | Deepest rail off, active low (S5 only) |
| wake_sts | output | 1 | Sticky wake status |
| throttle_off | output | 1 | Throttling forced off |

## Verification
The hardest case to reach is an override that fires at exactly the edge where a wake is also requested. That only happens when the last threshold tick and the wake event meet in the same clock. The stimulus controls `slow_tick` directly and counts ticks while the button is held. It then drives the final tick together with `wake_evt`, and also with a stale wake left pending from a low-battery period. Releasing the button for one clock just before the threshold exercises the counter restart, and an override issued while the controller is still waiting for stop-grant covers the path that needs no acknowledge.

// File: rtl/pm_sleep_pkg.sv
package pm_sleep_pkg;
   localparam int PM_TYPE_W = 3;
   localparam int PM_RAILS  = 3;
   localparam int PM_DEPTH_W = $clog2(PM_RAILS + 1);

   localparam logic [PM_TYPE_W-1:0] PM_CODE_S1 = 3'b001;
   localparam logic [PM_TYPE_W-1:0] PM_CODE_S3 = 3'b101;
   localparam logic [PM_TYPE_W-1:0] PM_CODE_S4 = 3'b110;
   localparam logic [PM_TYPE_W-1:0] PM_CODE_S5 = 3'b111;

   typedef enum logic [1:0] {
      PH_RUN    = 2'd0,
      PH_ENTER  = 2'd1,
      PH_ASLEEP = 2'd2
   } pm_phase_e;

   typedef logic [PM_DEPTH_W-1:0] pm_depth_t;

   typedef struct packed {
      logic      ok;
      pm_depth_t depth;
   } pm_decode_t;

   // depth = number of rail controls asserted in that sleep state
   function automatic pm_decode_t pm_decode(input logic [PM_TYPE_W-1:0] code);
      pm_decode_t d;
      d.ok    = 1'b1;
      d.depth = '0;
      unique case (code)
         PM_CODE_S1: d.depth = pm_depth_t'(0);
         PM_CODE_S3: d.depth = pm_depth_t'(1);
         PM_CODE_S4: d.depth = pm_depth_t'(2);
         PM_CODE_S5: d.depth = pm_depth_t'(3);
         default:    d.ok    = 1'b0;
      endcase
      return d;
   endfunction
endpackage

// File: rtl/pm_ovr_timer.sv
module pm_ovr_timer #(
   parameter int unsigned OVR_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_tick,
   input  logic btn_pressed,
   output logic ovr_fire
);
   localparam int unsigned LIMIT = OVR_TICKS + 1;
   localparam int unsigned CNT_W = $clog2(LIMIT + 1);

   generate
      if (OVR_TICKS < 1) begin : g_bad_ticks
         $error("pm_ovr_timer: OVR_TICKS must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   // fires on the tick that takes the held count past OVR_TICKS
   assign ovr_fire = btn_pressed && slow_tick && (cnt_q == CNT_W'(OVR_TICKS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!btn_pressed) begin
         cnt_q <= '0;
      end else if (slow_tick && (cnt_q != CNT_W'(LIMIT))) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pm_wake_gate.sv
module pm_wake_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic asleep,
   input  logic wake_evt,
   input  logic bat_low,
   input  logic flush,
   output logic wake_go
);
   logic pend_q;

   assign wake_go = asleep && (wake_evt || pend_q) && !bat_low;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (flush || wake_go) begin
         pend_q <= 1'b0;
      end else if (asleep && wake_evt) begin
         pend_q <= 1'b1;
      end
   end
endmodule

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
   import pm_sleep_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sleep_go,
   input  logic [PM_TYPE_W-1:0] type_code,
   input  logic                 stop_grant,
   input  logic                 ovr_fire,
   input  logic                 wake_go,
   output pm_phase_e            phase,
   output pm_depth_t            depth,
   output logic                 wake_done
);
   pm_phase_e  ph_q, ph_d;
   pm_depth_t  dp_q, dp_d;
   pm_decode_t dec;

   always_comb begin
      dec       = pm_decode(type_code);
      ph_d      = ph_q;
      dp_d      = dp_q;
      wake_done = 1'b0;
      if (ovr_fire) begin
         ph_d = PH_ASLEEP;
         dp_d = pm_depth_t'(PM_RAILS);
      end else begin
         unique case (ph_q)
            PH_RUN: begin
               if (sleep_go && dec.ok) begin
                  ph_d = PH_ENTER;
                  dp_d = dec.depth;
               end
            end
            PH_ENTER: begin
               if (stop_grant) ph_d = PH_ASLEEP;
            end
            PH_ASLEEP: begin
               if (wake_go) begin
                  ph_d      = PH_RUN;
                  wake_done = 1'b1;
               end
            end
            default: ph_d = PH_RUN;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q <= PH_RUN;
         dp_q <= '0;
      end else begin
         ph_q <= ph_d;
         dp_q <= dp_d;
      end
   end

   assign phase = ph_q;
   assign depth = dp_q;
endmodule

// File: rtl/pm_rail_drv.sv
module pm_rail_drv
   import pm_sleep_pkg::*;
#(
   parameter int  NUM_RAILS  = PM_RAILS,
   parameter bit  ACTIVE_LOW = 1'b1
) (
   input  pm_phase_e            phase,
   input  pm_depth_t            depth,
   output logic [NUM_RAILS-1:0] rail_out,
   output logic                 stpclk_out,
   output logic                 throttle_off
);
   generate
      if (NUM_RAILS < 1 || NUM_RAILS > PM_RAILS) begin : g_bad_rails
         $error("pm_rail_drv: NUM_RAILS out of range");
      end
   endgenerate

   logic [NUM_RAILS-1:0] rail_on;
   logic                 asleep;
   logic                 stop_on;

   assign asleep       = (phase == PH_ASLEEP);
   assign stop_on      = (phase != PH_RUN);
   assign throttle_off = stop_on;

   for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
      assign rail_on[i] = asleep && (int'(depth) > i);
   end

   generate
      if (ACTIVE_LOW) begin : g_low
         assign rail_out   = ~rail_on;
         assign stpclk_out = ~stop_on;
      end else begin : g_high
         assign rail_out   = rail_on;
         assign stpclk_out = stop_on;
      end
   endgenerate
endmodule

// File: rtl/pm_sleep_ctrl.sv
module pm_sleep_ctrl
   import pm_sleep_pkg::*;
#(
   parameter int unsigned OVR_TICKS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 slow_tick,
   input  logic                 type_wr,
   input  logic [PM_TYPE_W-1:0] type_in,
   input  logic                 sleep_go,
   input  logic                 stop_grant,
   input  logic                 btn_pressed,
   input  logic                 wake_evt,
   input  logic                 bat_low,
   input  logic                 wake_sts_w1c,
   output logic                 stpclk_n,
   output logic                 rail_a_n,
   output logic                 rail_b_n,
   output logic                 rail_c_n,
   output logic                 wake_sts,
   output logic                 throttle_off
);
   logic [PM_TYPE_W-1:0] type_q;
   logic                 ovr_fire;
   logic                 wake_go;
   logic                 wake_done;
   pm_phase_e            phase;
   pm_depth_t            depth;
   logic [PM_RAILS-1:0]  rails;
   logic                 wsts_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       type_q <= '0;
      else if (type_wr) type_q <= type_in;
   end

   pm_ovr_timer #(.OVR_TICKS(OVR_TICKS)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .slow_tick   (slow_tick),
      .btn_pressed (btn_pressed),
      .ovr_fire    (ovr_fire)
   );

   pm_wake_gate u_wake (
      .clk      (clk),
      .rst_n    (rst_n),
      .asleep   (phase == PH_ASLEEP),
      .wake_evt (wake_evt),
      .bat_low  (bat_low),
      .flush    (ovr_fire),
      .wake_go  (wake_go)
   );

   pm_state_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_go   (sleep_go),
      .type_code  (type_q),
      .stop_grant (stop_grant),
      .ovr_fire   (ovr_fire),
      .wake_go    (wake_go),
      .phase      (phase),
      .depth      (depth),
      .wake_done  (wake_done)
   );

   pm_rail_drv #(.NUM_RAILS(PM_RAILS), .ACTIVE_LOW(1'b1)) u_drv (
      .phase        (phase),
      .depth        (depth),
      .rail_out     (rails),
      .stpclk_out   (stpclk_n),
      .throttle_off (throttle_off)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)            wsts_q <= 1'b0;
      else if (wake_done)    wsts_q <= 1'b1;
      else if (wake_sts_w1c) wsts_q <= 1'b0;
   end

   assign rail_a_n = rails[0];
   assign rail_b_n = rails[1];
   assign rail_c_n = rails[2];
   assign wake_sts = wsts_q;
endmodule

// File: rtl/pm_sleep_ctrl_chk.sv
module pm_sleep_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic stop_grant,
   input logic btn_pressed,
   input logic bat_low,
   input logic wake_sts_w1c,
   input logic stpclk_n,
   input logic rail_a_n,
   input logic rail_b_n,
   input logic rail_c_n,
   input logic wake_sts,
   input logic throttle_off
);
   p_rail_needs_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rail_a_n || !rail_b_n || !rail_c_n) |-> !stpclk_n);

   p_rail_c_nest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rail_c_n |-> !rail_b_n);

   p_rail_b_nest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rail_b_n |-> !rail_a_n);

   p_grant_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!stpclk_n && rail_a_n && rail_b_n && rail_c_n && !stop_grant && !btn_pressed)
      |=> (rail_a_n && rail_b_n && rail_c_n));

   p_wake_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stpclk_n) |-> wake_sts);

   p_batlow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bat_low && !stpclk_n) |=> !stpclk_n);

   p_throttle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !stpclk_n |-> throttle_off);

   p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_sts_w1c && stpclk_n) |=> !wake_sts);
endmodule

bind pm_sleep_ctrl pm_sleep_ctrl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .stop_grant   (stop_grant),
   .btn_pressed  (btn_pressed),
   .bat_low      (bat_low),
   .wake_sts_w1c (wake_sts_w1c),
   .stpclk_n     (stpclk_n),
   .rail_a_n     (rail_a_n),
   .rail_b_n     (rail_b_n),
   .rail_c_n     (rail_c_n),
   .wake_sts     (wake_sts),
   .throttle_off (throttle_off)
);

// File: tb/pm_sleep_ctrl_bench.sv
`timescale 1ns/1ps
module pm_sleep_ctrl_bench;
   localparam int OVR = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slow_tick = 0, type_wr = 0, sleep_go = 0, stop_grant = 0;
   logic btn_pressed = 0, wake_evt = 0, bat_low = 0, wake_sts_w1c = 0;
   logic [2:0] type_in = 3'b000;
   logic stpclk_n, rail_a_n, rail_b_n, rail_c_n, wake_sts, throttle_off;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   pm_sleep_ctrl #(.OVR_TICKS(OVR)) u_pm_sleep_ctrl (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .type_wr(type_wr),
      .type_in(type_in), .sleep_go(sleep_go), .stop_grant(stop_grant),
      .btn_pressed(btn_pressed), .wake_evt(wake_evt), .bat_low(bat_low),
      .wake_sts_w1c(wake_sts_w1c), .stpclk_n(stpclk_n), .rail_a_n(rail_a_n),
      .rail_b_n(rail_b_n), .rail_c_n(rail_c_n), .wake_sts(wake_sts),
      .throttle_off(throttle_off));

   // reference model: m_st 0 = working, 1 = waiting for grant, 2 = asleep
   int m_st = 0, m_depth = 0, m_cnt = 0;
   bit m_pend = 0, m_ws = 0;
   logic [2:0] m_type = 3'b000;

   function automatic int depth_of(input logic [2:0] c);
      case (c)
         3'b001: return 0;
         3'b101: return 1;
         3'b110: return 2;
         3'b111: return 3;
         default: return -1;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_depth = 0; m_cnt = 0; m_pend = 0; m_ws = 0; m_type = 3'b000;
      end else begin
         bit fire, wk, setws;
         fire  = btn_pressed && slow_tick && (m_cnt == OVR);
         wk    = (m_st == 2) && (wake_evt || m_pend) && !bat_low;
         setws = 0;
         if (!btn_pressed) m_cnt = 0;
         else if (slow_tick && m_cnt < OVR + 1) m_cnt++;
         if (fire) begin
            m_st = 2; m_depth = 3; m_pend = 0;
         end else if (m_st == 0) begin
            if (sleep_go && depth_of(m_type) >= 0) begin
               m_st = 1; m_depth = depth_of(m_type);
            end
         end else if (m_st == 1) begin
            if (stop_grant) m_st = 2;
         end else begin
            if (wk) begin m_st = 0; m_pend = 0; setws = 1; end
            else if (wake_evt) m_pend = 1;
         end
         if (setws) m_ws = 1;
         else if (wake_sts_w1c) m_ws = 0;
         if (type_wr) m_type = type_in;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [2:0] er;
         for (int i = 0; i < 3; i++) er[i] = !((m_st == 2) && (m_depth > i));
         checks += 4;
         if (stpclk_n !== (m_st == 0)) begin
            fails++; $display("FAIL R2 model stpclk_n act=%b exp=%b t=%0t", stpclk_n, (m_st == 0), $time);
         end
         if ({rail_c_n, rail_b_n, rail_a_n} !== er) begin
            fails++; $display("FAIL R4 model rails act=%b exp=%b t=%0t", {rail_c_n, rail_b_n, rail_a_n}, er, $time);
         end
         if (throttle_off !== (m_st != 0)) begin
            fails++; $display("FAIL R9 model throttle_off act=%b exp=%b t=%0t", throttle_off, (m_st != 0), $time);
         end
         if (wake_sts !== m_ws) begin
            fails++; $display("FAIL R10 model wake_sts act=%b exp=%b t=%0t", wake_sts, m_ws, $time);
         end
      end
   end

   task automatic expect_out(input string tag, input logic e_stp,
                             input logic [2:0] e_rails, input logic e_ws);
      checks++;
      if (stpclk_n !== e_stp || {rail_c_n, rail_b_n, rail_a_n} !== e_rails || wake_sts !== e_ws) begin
         fails++;
         $display("FAIL %s act stp=%b rails=%b ws=%b exp stp=%b rails=%b ws=%b",
                  tag, stpclk_n, {rail_c_n, rail_b_n, rail_a_n}, wake_sts, e_stp, e_rails, e_ws);
      end
   endtask

   task automatic cyc(); @(negedge clk); endtask

   task automatic set_type(input logic [2:0] c);
      type_in = c; type_wr = 1; cyc(); type_wr = 0;
   endtask
   task automatic go(); sleep_go = 1; cyc(); sleep_go = 0; endtask
   task automatic grant(); stop_grant = 1; cyc(); stop_grant = 0; endtask
   task automatic wake(); wake_evt = 1; cyc(); wake_evt = 0; endtask
   task automatic clr(); wake_sts_w1c = 1; cyc(); wake_sts_w1c = 0; endtask
   task automatic tick(); slow_tick = 1; cyc(); slow_tick = 0; cyc(); endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1; fails++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) cyc();
      rst_n = 1;
      cyc();
      expect_out("R7 reset state", 1'b1, 3'b111, 1'b0);

      // R1 invalid code ignored
      set_type(3'b010); go(); cyc();
      expect_out("R1 invalid type ignored", 1'b1, 3'b111, 1'b0);
      set_type(3'b100); go(); cyc();
      expect_out("R1 invalid type 100 ignored", 1'b1, 3'b111, 1'b0);

      // R1/R2/R3 S1 entry
      set_type(3'b001); go();
      expect_out("R1 stop-clock after go", 1'b0, 3'b111, 1'b0);
      repeat (5) cyc();
      expect_out("R2 rails held before grant", 1'b0, 3'b111, 1'b0);
      wake(); cyc();
      expect_out("R11 wake ignored while entering", 1'b0, 3'b111, 1'b0);
      grant();
      expect_out("R3 S1 state", 1'b0, 3'b111, 1'b0);
      go(); cyc();
      expect_out("R11 go ignored while asleep", 1'b0, 3'b111, 1'b0);
      wake();
      expect_out("R7 wake from S1", 1'b1, 3'b111, 1'b1);
      cyc();
      expect_out("R10 wake_sts sticky", 1'b1, 3'b111, 1'b1);
      clr();
      expect_out("R10 wake_sts cleared", 1'b1, 3'b111, 1'b0);
      wake(); cyc();
      expect_out("R11 wake in S0 ignored", 1'b1, 3'b111, 1'b0);

      // R4 S3, S4, S5
      set_type(3'b101); go(); grant();
      expect_out("R4 S3 rails", 1'b0, 3'b110, 1'b0);
      wake(); clr();
      set_type(3'b110); go(); grant();
      expect_out("R4 S4 rails", 1'b0, 3'b100, 1'b0);
      wake(); clr();
      set_type(3'b111); go(); grant();
      expect_out("R4 S5 rails", 1'b0, 3'b000, 1'b0);

      // R10 set beats clear
      wake_evt = 1; wake_sts_w1c = 1; cyc(); wake_evt = 0; wake_sts_w1c = 0;
      expect_out("R10 set wins over clear", 1'b1, 3'b111, 1'b1);
      clr();

      // R8 low-battery hold
      set_type(3'b101); go(); grant();
      bat_low = 1; wake();
      repeat (6) cyc();
      expect_out("R8 held asleep under bat_low", 1'b0, 3'b110, 1'b0);
      bat_low = 0; cyc();
      expect_out("R8 latched wake after bat_low", 1'b1, 3'b111, 1'b1);
      clr();

      // R6 release restarts count, R5 override from S0
      btn_pressed = 1; repeat (3) tick();
      btn_pressed = 0; cyc(); btn_pressed = 1;
      repeat (OVR) tick();
      expect_out("R6 count restarted after release", 1'b1, 3'b111, 1'b0);
      slow_tick = 1; cyc(); slow_tick = 0;
      expect_out("R5 override from S0", 1'b0, 3'b000, 1'b0);
      repeat (3) tick();
      expect_out("R5 held button no refire", 1'b0, 3'b000, 1'b0);
      btn_pressed = 0; wake(); clr();

      // R5 override while waiting for grant
      set_type(3'b110); go();
      btn_pressed = 1; repeat (OVR) tick();
      expect_out("R2 still waiting for grant", 1'b0, 3'b111, 1'b0);
      slow_tick = 1; cyc(); slow_tick = 0;
      expect_out("R5 override skips grant", 1'b0, 3'b000, 1'b0);
      btn_pressed = 0; wake(); clr();

      // R12 override and wake at the same edge, pending dropped
      set_type(3'b101); go(); grant();
      bat_low = 1; wake(); bat_low = 0;
      bat_low = 1;
      btn_pressed = 1; repeat (OVR) tick();
      bat_low = 0; slow_tick = 1; wake_evt = 1; cyc(); slow_tick = 0; wake_evt = 0;
      expect_out("R12 override wins over wake", 1'b0, 3'b000, 1'b0);
      btn_pressed = 0; repeat (3) cyc();
      expect_out("R12 pending wake dropped", 1'b0, 3'b000, 1'b0);
      wake();
      expect_out("R7 wake from S5 after override", 1'b1, 3'b111, 1'b1);
      clr(); repeat (3) cyc();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule